// File: doc/BRIEF.md
# Two-Byte Serial Converter Command Writer

This block sits on the host side of a three-wire link to a 12-bit serial converter. It accepts a 12-bit output code and a 2-bit operating mode, which selects normal operation or one of the low-power output states. A single start strobe launches the transfer. The block builds one 16-bit command from these inputs and sends it as two back-to-back 8-bit bursts. An active-low frame select stays asserted across both bursts. The serial clock rests low. The data line changes on each rising clock edge, so it is steady at the falling edge where the receiver samples it.

Between commands the frame select rests low, because the receiver draws less current that way. When a new command starts, the block first drives frame select high for a programmed minimum time and then pulls it low to open the frame. After the sixteenth falling clock edge, frame select stays low for one further half clock period. It then rises for one cycle and returns to rest. A one-cycle done pulse marks the end, and a busy flag covers the whole transaction.

Two things are set from parameters: the half period of the serial clock and the width of the frame-select high pulse. Both are derived from the system clock rate, the highest serial clock rate allowed and the minimum high time. The byte engine can shift either most-significant bit first or least-significant bit first. With the second variant each byte is bit-reversed before it is loaded, so the bit order on the wire does not change.

Top module: `dacw_master`

## Requirements
- R1: While reset is asserted, and from the first cycle after it, sel_n, sclk, sdo, busy and done are all 0, including when reset arrives in the middle of a frame.
- R2: A start strobe taken while idle produces exactly one frame of 16 bits, sent most significant bit first. The bits sampled at the falling sclk edges equal {2'b00, mode[1:0], code[11:0]}: bits 15:14 are zero, bits 13:12 carry the mode and bits 11:0 carry the code.
- R3: sel_n stays low without a break from before the first rising sclk edge until after the 16th falling edge, including the gap between bit 8 and bit 9. sclk is never high while sel_n is high.
- R4: sclk rests low. Every high phase and every low phase inside a frame lasts exactly HALF_CYC system cycles. sdo changes only together with a rising sclk edge, or while sclk is low, and never in the cycle of a falling edge.
- R5: Before each frame, sel_n is high for exactly SEL_HIGH_CYC cycles and then low for at least HALF_CYC cycles before the first rising sclk edge.
- R6: After the 16th falling edge, sel_n stays low for at least HALF_CYC cycles, is then high for exactly one cycle, and then returns low. done is high for exactly one cycle, which is the cycle in which sel_n returns low.
- R7: busy is 1 from the cycle after a start is accepted up to, but not including, the done cycle. busy is 0 in the done cycle. A start that is present in the done cycle is accepted.
- R8: A start strobe seen while busy is 1 is ignored. It produces no extra frame, and the frame already in progress keeps its original code and mode.
- R9: The least-significant-bit-first engine variant (LSB_FIRST_ENGINE=1) produces the same serial bit sequence as the default variant for the same code and mode.
- R10: While idle, sel_n and sclk are held low indefinitely.
- R11: HALF_CYC is the smallest whole number of system cycles for which the serial clock stays at or below SCLK_MAX_MHZ. SEL_HIGH_CYC is the smallest whole number of cycles whose length covers SEL_MIN_NS. Both are at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe; sampled only while idle |
| code | input | 12 | Output code to send |
| mode | input | 2 | Operating-mode field to send |
| busy | output | 1 | High while a transaction is in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| sel_n | output | 1 | Active-low frame select |
| sclk | output | 1 | Serial clock, resting low |
| sdo | output | 1 | Serial data, most significant bit first |

## Verification
The hardest situation to reach from the ports is the boundary between two transactions. This is the single idle cycle that carries the done pulse, right after the one-cycle release of frame select. A start placed exactly there must be accepted, and it must still produce a full-width high pulse ahead of the next frame. The bench watches the done output on the falling clock edge and raises start in that same cycle, so the release pulse and the fresh pre-frame pulse follow each other with one low cycle in between. A second hard case is a start held high across the middle of a frame. The bench holds start for ten cycles with a different code while busy is set, and then confirms that only the first code reached the wire.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 2;
  localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
  localparam int MODE_W      = 2;
  localparam int CODE_W      = 12;
  localparam int PAD_W       = FRAME_BITS - MODE_W - CODE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SETUP,
    ST_SHIFT,
    ST_REL
  } fsm_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // System cycles per serial half period, never faster than the limit.
  function automatic int half_cycles(input int clk_mhz, input int sclk_max_mhz);
    int h;
    h = ceil_div(clk_mhz, 2 * sclk_max_mhz);
    return (h < 1) ? 1 : h;
  endfunction

  // System cycles covering a minimum frame-select high time in ns.
  function automatic int sel_high_cycles(input int clk_mhz, input int min_ns);
    int c;
    c = ceil_div(clk_mhz * min_ns, 1000);
    return (c < 1) ? 1 : c;
  endfunction

  // Command layout: zero pad, mode field, code field.
  function automatic logic [FRAME_BITS-1:0] build_word(input logic [MODE_W-1:0] md,
                                                       input logic [CODE_W-1:0] cd);
    return {{PAD_W{1'b0}}, md, cd};
  endfunction

  function automatic logic [BYTE_W-1:0] mirror_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/dacw_slot_timer.sv
module dacw_slot_timer #(
  parameter int HALF_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic slot_end
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign slot_end = (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (restart || slot_end) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dacw_byte_shifter.sv
module dacw_byte_shifter
  import dacw_pkg::*;
#(
  parameter bit LSB_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              shift,
  output logic              bit_out
);
  logic [BYTE_W-1:0] sh_q;

  generate
    if (LSB_FIRST) begin : g_lsb
      // Engine emits bit 0 first: reverse the byte so the wire stays MSB first.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= mirror_byte(load_byte);
        else if (shift) sh_q <= {1'b0, sh_q[BYTE_W-1:1]};
      end
      assign bit_out = sh_q[0];
    end else begin : g_msb
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= load_byte;
        else if (shift) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
      end
      assign bit_out = sh_q[BYTE_W-1];
    end
  endgenerate
endmodule

// File: rtl/dacw_master.sv
module dacw_master
  import dacw_pkg::*;
#(
  parameter int CLK_MHZ          = 250,
  parameter int SCLK_MAX_MHZ     = 30,
  parameter int SEL_MIN_NS       = 33,
  parameter bit LSB_FIRST_ENGINE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [11:0] code,
  input  logic [1:0]  mode,
  output logic        busy,
  output logic        done,
  output logic        sel_n,
  output logic        sclk,
  output logic        sdo
);
  localparam int HALF_CYC     = half_cycles(CLK_MHZ, SCLK_MAX_MHZ);
  localparam int SEL_HIGH_CYC = sel_high_cycles(CLK_MHZ, SEL_MIN_NS);
  localparam int GAP_W        = (SEL_HIGH_CYC > 1) ? $clog2(SEL_HIGH_CYC) : 1;
  localparam int BIT_W        = $clog2(FRAME_BITS);
  localparam int BSEL_W       = $clog2(BYTE_W);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(SEL_HIGH_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  fsm_e                  st_q;
  logic [FRAME_BITS-1:0] word_q;
  logic [GAP_W-1:0]      gap_q;
  logic [BIT_W-1:0]      bit_q;
  logic                  phase_lo_q;
  logic                  sel_n_q, sclk_q, done_q;

  logic                  slot_end;
  logic [BYTE_W-1:0]     next_byte;
  logic [BYTE_W-1:0]     load_byte;

  // Named internal events, also watched by the bound checker.
  logic ev_accept;     // start taken while idle
  logic ev_setup;      // pre-frame high pulse ends, frame select drops
  logic ev_rise;       // sclk about to rise inside the frame body
  logic ev_byte_next;  // next byte loaded at a byte boundary
  logic ev_shift;      // shift to the next bit of the current byte

  assign ev_accept    = (st_q == ST_IDLE) && start;
  assign ev_setup     = (st_q == ST_GAP) && (gap_q == GAP_LAST);
  assign ev_rise      = (st_q == ST_SHIFT) && slot_end && phase_lo_q && (bit_q != BIT_LAST);
  assign ev_byte_next = ev_rise && (bit_q[BSEL_W-1:0] == {BSEL_W{1'b1}});
  assign ev_shift     = ev_rise && !ev_byte_next;

  always_comb begin
    next_byte = word_q[FRAME_BITS-1 -: BYTE_W];
    for (int b = 1; b < FRAME_BYTES; b++) begin
      if (bit_q == BIT_W'(b * BYTE_W - 1)) next_byte = word_q[FRAME_BITS-1-b*BYTE_W -: BYTE_W];
    end
  end

  assign load_byte = ev_setup ? word_q[FRAME_BITS-1 -: BYTE_W] : next_byte;

  dacw_slot_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (ev_setup),
    .slot_end (slot_end)
  );

  dacw_byte_shifter #(.LSB_FIRST(LSB_FIRST_ENGINE)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_setup || ev_byte_next),
    .load_byte (load_byte),
    .shift     (ev_shift),
    .bit_out   (sdo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      word_q     <= '0;
      gap_q      <= '0;
      bit_q      <= '0;
      phase_lo_q <= 1'b0;
      sel_n_q    <= 1'b0;
      sclk_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (ev_accept) begin
            word_q  <= build_word(mode, code);
            gap_q   <= '0;
            sel_n_q <= 1'b1;
            st_q    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (ev_setup) begin
            sel_n_q <= 1'b0;
            st_q    <= ST_SETUP;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_SETUP: begin
          if (slot_end) begin
            sclk_q     <= 1'b1;
            bit_q      <= '0;
            phase_lo_q <= 1'b0;
            st_q       <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (slot_end) begin
            if (!phase_lo_q) begin
              sclk_q     <= 1'b0;
              phase_lo_q <= 1'b1;
            end else if (bit_q == BIT_LAST) begin
              sel_n_q <= 1'b1;
              st_q    <= ST_REL;
            end else begin
              bit_q      <= bit_q + 1'b1;
              phase_lo_q <= 1'b0;
              sclk_q     <= 1'b1;
            end
          end
        end
        ST_REL: begin
          sel_n_q <= 1'b0;
          done_q  <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign done  = done_q;
  assign sel_n = sel_n_q;
  assign sclk  = sclk_q;
endmodule

// File: rtl/dacw_master_chk.sv
module dacw_master_chk #(
  parameter int HALF_CYC     = 5,
  parameter int SEL_HIGH_CYC = 9
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sel_n,
  input logic sclk,
  input logic sdo,
  input logic ev_accept
);
  logic [15:0] lo_run, hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= '0;
    end else begin
      lo_run <= sel_n ? 16'd0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1);
      hi_run <= !sel_n ? 16'd0 : ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1);
    end
  end

  p_no_clk_when_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !sclk);

  p_sdo_steady_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdo));

  p_pre_frame_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sel_n) && busy) |-> (hi_run == 16'(SEL_HIGH_CYC)));

  p_setup_before_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (lo_run >= 16'(HALF_CYC)));

  p_done_after_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(sel_n) && !sel_n && !busy));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (busy && sel_n));

  p_start_ignored_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |-> !ev_accept);

  p_idle_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sel_n && !sclk));
endmodule

bind dacw_master dacw_master_chk #(
  .HALF_CYC     (HALF_CYC),
  .SEL_HIGH_CYC (SEL_HIGH_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .sel_n     (sel_n),
  .sclk      (sclk),
  .sdo       (sdo),
  .ev_accept (ev_accept)
);

// File: tb/tb_dacw_master.sv
`timescale 1ns/1ps

module tb_frame_mon (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic sclk,
  input logic sdo,
  input logic done
);
  logic [15:0] word, acc;
  int nbits, frames, dones, pre_hi, setup, hold, rel_hi, min_ph, max_ph, bad;
  int acc_n, f_min, f_max, sel_run, sclk_run;
  logic p_sel, p_sclk, p_sdo, p_done;
  bit await_rel;

  always @(negedge clk) begin
    if (!rst_n) begin
      word = '0; acc = '0; nbits = 0; frames = 0; dones = 0; pre_hi = 0; setup = 0;
      hold = 0; rel_hi = 0; min_ph = 0; max_ph = 0; bad = 0; acc_n = 0;
      f_min = 1 << 20; f_max = 0; sel_run = 0; sclk_run = 0;
      p_sel = 0; p_sclk = 0; p_sdo = 0; p_done = 0; await_rel = 0;
    end else begin
      if (sclk != p_sclk) begin
        if (!sclk) begin
          acc = {acc[14:0], p_sdo};
          acc_n++;
          if (sdo != p_sdo) bad++;
          if (sclk_run < f_min) f_min = sclk_run;
          if (sclk_run > f_max) f_max = sclk_run;
        end else begin
          if (acc_n == 0) setup = sel_run;
          else begin
            if (sclk_run < f_min) f_min = sclk_run;
            if (sclk_run > f_max) f_max = sclk_run;
          end
        end
      end else if (sclk && p_sclk && sdo != p_sdo) bad++;
      if (sclk && sel_n) bad++;
      if (sel_n != p_sel) begin
        if (sel_n) begin
          if (acc_n > 0) begin
            word = acc; nbits = acc_n; hold = sclk_run; min_ph = f_min; max_ph = f_max;
            frames++; await_rel = 1; acc_n = 0; acc = '0; f_min = 1 << 20; f_max = 0;
          end
        end else begin
          if (await_rel) begin rel_hi = sel_run; await_rel = 0; end
          else pre_hi = sel_run;
        end
      end
      if (done) begin
        dones++;
        if (!(p_sel && !sel_n)) bad++;
        if (p_done) bad++;
      end
      sel_run  = (sel_n != p_sel) ? 1 : sel_run + 1;
      sclk_run = (sclk != p_sclk) ? 1 : sclk_run + 1;
      p_sel = sel_n; p_sclk = sclk; p_sdo = sdo; p_done = done;
    end
  end
endmodule

module tb_dacw_master;
  localparam int HALF_A  = (250 + 2 * 30 - 1) / (2 * 30);
  localparam int SELHI_A = (33 * 250 + 999) / 1000;
  localparam int HALF_B  = (250 + 2 * 20 - 1) / (2 * 20);
  localparam int SELHI_B = (50 * 250 + 999) / 1000;
  localparam int NV = 8;
  // {mode, code}
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 12'h000}, {2'd3, 12'hFFF}, {2'd1, 12'hA5C}, {2'd2, 12'h3C1},
    {2'd0, 12'h800}, {2'd3, 12'h7FF}, {2'd1, 12'h001}, {2'd2, 12'h80F}
  };

  logic clk = 1'b0;
  logic rst_n, start_a, start_b;
  logic [11:0] code;
  logic [1:0] mode;
  logic busy_a, done_a, sel_n_a, sclk_a, sdo_a;
  logic busy_b, done_b, sel_n_b, sclk_b, sdo_b;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dacw_master dut (
    .clk(clk), .rst_n(rst_n), .start(start_a), .code(code), .mode(mode),
    .busy(busy_a), .done(done_a), .sel_n(sel_n_a), .sclk(sclk_a), .sdo(sdo_a));

  dacw_master #(.CLK_MHZ(250), .SCLK_MAX_MHZ(20), .SEL_MIN_NS(50), .LSB_FIRST_ENGINE(1'b1)) dut_lsb (
    .clk(clk), .rst_n(rst_n), .start(start_b), .code(code), .mode(mode),
    .busy(busy_b), .done(done_b), .sel_n(sel_n_b), .sclk(sclk_b), .sdo(sdo_b));

  tb_frame_mon mon_a (.clk(clk), .rst_n(rst_n), .sel_n(sel_n_a), .sclk(sclk_a), .sdo(sdo_a), .done(done_a));
  tb_frame_mon mon_b (.clk(clk), .rst_n(rst_n), .sel_n(sel_n_b), .sclk(sclk_b), .sdo(sdo_b), .done(done_b));

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_ge(input string req, input string what, input longint act, input longint lim);
    n_chk++;
    if (act < lim) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
    end
  endtask

  task automatic chk_frame(input string who, input int half, input int selhi, input logic [15:0] exp,
                           input logic [15:0] word, input int nbits, input int pre_hi, input int setup,
                           input int hold, input int rel_hi, input int min_ph, input int max_ph, input int bad);
    check("R2", {who, " word"}, word, exp);
    check("R3", {who, " bit count under one select"}, nbits, 16);
    check("R5", {who, " pre-frame high"}, pre_hi, selhi);
    check_ge("R5", {who, " setup"}, setup, half);
    check("R4", {who, " min phase"}, min_ph, half);
    check("R4", {who, " max phase"}, max_ph, half);
    check_ge("R6", {who, " hold"}, hold, half);
    check("R6", {who, " release width"}, rel_hi, 1);
    check("R4", {who, " protocol faults"}, bad, 0);
  endtask

  task automatic wait_done_a(input int since);
    while (mon_a.dones == since) @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_a = 1'b0; start_b = 1'b0; code = '0; mode = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "a outputs in reset", {sel_n_a, sclk_a, sdo_a, busy_a, done_a}, 0);
    check("R1", "b outputs in reset", {sel_n_b, sclk_b, sdo_b, busy_b, done_b}, 0);
    check("R11", "a half period", dut.HALF_CYC, HALF_A);
    check("R11", "b select width", dut_lsb.SEL_HIGH_CYC, SELHI_B);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "idle parked", {sel_n_a, sclk_a, sel_n_b, sclk_b}, 0);

    // Vector table, both variants in parallel
    for (int i = 0; i < NV; i++) begin
      int da, db;
      logic [15:0] exp;
      exp = {2'b00, VEC[i]};
      code = VEC[i][11:0]; mode = VEC[i][13:12];
      @(posedge clk); da = mon_a.dones; db = mon_b.dones;
      @(negedge clk);
      start_a = 1'b1; start_b = 1'b1;
      @(negedge clk);
      start_a = 1'b0; start_b = 1'b0;
      check("R7", "busy after accept", {busy_a, busy_b}, 2'b11);
      while (mon_a.dones == da || mon_b.dones == db) @(posedge clk);
      @(posedge clk);
      chk_frame("a", HALF_A, SELHI_A, exp, mon_a.word, mon_a.nbits, mon_a.pre_hi, mon_a.setup,
                mon_a.hold, mon_a.rel_hi, mon_a.min_ph, mon_a.max_ph, mon_a.bad);
      while (busy_b) @(posedge clk);
      chk_frame("b", HALF_B, SELHI_B, exp, mon_b.word, mon_b.nbits, mon_b.pre_hi, mon_b.setup,
                mon_b.hold, mon_b.rel_hi, mon_b.min_ph, mon_b.max_ph, mon_b.bad);
      check("R9", "lsb-first variant matches", mon_b.word, mon_a.word);
      check("R7", "busy low after done", busy_a, 0);
      @(negedge clk);
    end

    // R8: start while busy is ignored
    begin
      int da, fa;
      code = 12'h5A3; mode = 2'd1;
      @(posedge clk); da = mon_a.dones; fa = mon_a.frames;
      @(negedge clk); start_a = 1'b1;
      @(negedge clk); start_a = 1'b0;
      repeat (20) @(negedge clk);
      code = 12'hC3E; mode = 2'd2; start_a = 1'b1;
      repeat (10) @(negedge clk);
      start_a = 1'b0;
      wait_done_a(da);
      check("R8", "frame keeps first code", mon_a.word, 16'h15A3);
      repeat (300) @(negedge clk);
      check("R8", "no extra frame", mon_a.frames, fa + 1);
      check("R10", "parked low after long idle", {sel_n_a, sclk_a, busy_a}, 0);
    end

    // R7/R6: start placed in the done cycle is accepted
    begin
      int da;
      code = 12'h0F0; mode = 2'd3;
      @(negedge clk); start_a = 1'b1;
      @(negedge clk); start_a = 1'b0;
      while (!done_a) @(negedge clk);
      code = 12'h9C6; mode = 2'd0; start_a = 1'b1;
      @(negedge clk); start_a = 1'b0;
      check("R7", "start in done cycle accepted", {busy_a, sel_n_a}, 2'b11);
      @(posedge clk); da = mon_a.dones;
      check("R2", "first of back-to-back", mon_a.word, 16'h30F0);
      wait_done_a(da);
      chk_frame("a b2b", HALF_A, SELHI_A, 16'h09C6, mon_a.word, mon_a.nbits, mon_a.pre_hi, mon_a.setup,
                mon_a.hold, mon_a.rel_hi, mon_a.min_ph, mon_a.max_ph, mon_a.bad);
    end

    // R1: reset in the middle of a frame
    begin
      int da;
      code = 12'hFFF; mode = 2'd3;
      @(negedge clk); start_a = 1'b1;
      @(negedge clk); start_a = 1'b0;
      repeat (60) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "mid-frame reset", {sel_n_a, sclk_a, sdo_a, busy_a, done_a}, 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "after reset release", {sel_n_a, sclk_a, busy_a}, 0);
      code = 12'h2B7; mode = 2'd2;
      @(posedge clk); da = mon_a.dones;
      @(negedge clk); start_a = 1'b1;
      @(negedge clk); start_a = 1'b0;
      wait_done_a(da);
      check("R2", "frame after reset", mon_a.word, 16'h22B7);
      check("R3", "bit count after reset", mon_a.nbits, 16);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule